// File: doc/BRIEF.md
# Four-Channel Countdown Timer Bank

The block holds four independent countdown timers behind a 32-bit register window. Each timer is started by writing a reload value with its stop bit clear. It then counts down once every `DIV_RATIO` clock cycles. When the count runs out it reloads itself, flips a phase bit and raises a one-cycle interrupt pulse on its own output line. Software can see the live count and the phase bit through a read-only count word.

Each timer also keeps two 32-bit words, a vector/priority word and a destination word. The bank keeps one frequency word as well. The block only stores these words; routing and arbitration of the pulses happen outside it.

Register offsets are counted from the start of the window. The frequency word is at 0x000. Timer *n* owns a 64-byte group at 0x010 + 0x40·*n*. Inside a group the words sit as follows:
- count word at +0x00
- reload word at +0x10
- vector/priority word at +0x20
- destination word at +0x30

Reads are combinational from `addr`. Writes take effect on the clock edge where `wr_en` is high.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every reload word reads 0x8000_0000 (stop bit 31 set), every count word reads 0, the frequency word reads `FREQ_RST`, and all `irq_pulse` bits are low.
- R2: The frequency word is at offset 0x000. Timer *n* has its count word at 0x010+0x40·*n*, its reload word at +0x10, its vector/priority word at +0x20 and its destination word at +0x30. The frequency, vector and destination words read back the full 32-bit value last written, and a write to one word changes no other word.
- R3: An access whose `addr[3:0]` is non-zero is ignored: a write changes nothing and a read returns 0xFFFF_FFFF. A read of any offset outside the map also returns 0xFFFF_FFFF.
- R4: Writes to a count word are ignored.
- R5: A reload-word write that changes bit 31 from 1 to 0 does three things: it loads the count with `wdata[30:0]`, keeps the phase bit, and restarts the prescaler, so that the first decrement lands exactly `DIV_RATIO` cycles later.
- R6: While a timer runs, its count drops by one every `DIV_RATIO` clock cycles.
- R7: When a decrement would bring the count to zero, the count instead reloads from reload bits [30:0], and the phase bit (count word bit 31) inverts. Its `irq_pulse` bit is then high for exactly one cycle, the cycle after that edge. With reload N, the pulse follows the N·`DIV_RATIO`-th edge after the enable.
- R8: A reload-word write that sets bit 31 stops the timer and clears the count while keeping the phase bit. No pulse occurs while the timer is stopped.
- R9: A running timer whose count and reload are both zero stays idle: no pulse and no phase change. Once a non-zero reload is written, the next prescaler tick loads it, without a pulse, and counting resumes.
- R10: Timers are independent: activity on one never pulses another's `irq_pulse` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W (9 by default) | Byte offset within the timer window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_pulse | output | N_TMR | One-cycle expiry pulse per timer |

## Verification
The bench builds the bank with four timers, `DIV_RATIO` of 4 and a non-zero frequency reset value. The short divide ratio lets a three-count period expire in twelve cycles. That makes the exact pulse cycle, three successive expiries with phase flips, and the prescaler restart on re-enable all cheap to observe. The non-zero frequency default makes the reset value of that word distinguishable from a cleared register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WORD_W     = 32;
  localparam int STOP_BIT   = 31;
  localparam int GRP_BASE   = 16;
  localparam int GRP_STRIDE = 64;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_RLD  = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_DEST = 2'd3
  } tmr_sel_e;

  typedef struct packed {
    logic [30:0] cnt;
    logic        expire;
  } step_t;

  // One prescaler tick: decrement, reload on reaching zero, idle-load when empty.
  function automatic step_t count_step(input logic [30:0] cur, input logic [30:0] rld);
    step_t s;
    s.expire = 1'b0;
    if (cur == 31'd0) begin
      s.cnt = rld;
    end else if (cur == 31'd1) begin
      s.cnt    = rld;
      s.expire = 1'b1;
    end else begin
      s.cnt = cur - 31'd1;
    end
    return s;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 8,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  logic [PW-1:0] pre_q;
  logic          at_end;

  assign at_end = (pre_q == PW'(DIV - 1));
  assign tick   = en && !clr && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clr)    pre_q <= '0;
    else if (en)     pre_q <= at_end ? '0 : pre_q + PW'(1);
  end
endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int ADDR_W = 9,
  localparam int IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1,
  localparam int GSH   = $clog2(GRP_STRIDE)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_freq,
  output logic              hit_grp,
  output logic [IDX_W-1:0]  grp_idx,
  output tmr_sel_e          sel
);
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] grp;
  logic              aligned;

  always_comb begin
    rel      = addr - ADDR_W'(GRP_BASE);
    aligned  = (rel[3:0] == 4'd0);
    grp      = rel >> GSH;
    hit_freq = aligned && (addr == '0);
    hit_grp  = aligned && (addr >= ADDR_W'(GRP_BASE)) && (grp < ADDR_W'(N_TMR));
    grp_idx  = grp[IDX_W-1:0];
    sel      = tmr_sel_e'(rel[5:4]);
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_rld,
  input  logic              we_vec,
  input  logic              we_dest,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cnt_word,
  output logic [WORD_W-1:0] rld_word,
  output logic [WORD_W-1:0] vec_word,
  output logic [WORD_W-1:0] dest_word,
  output logic              irq,
  output logic              tick_o,
  output logic              expire_o,
  output logic              run_o
);
  logic [WORD_W-1:0] rld_q, vec_q, dest_q;
  logic [30:0]       cnt_q;
  logic              phase_q, irq_q;
  logic              running, start_evt, stop_evt, tick, expire;
  step_t             step;

  assign running   = !rld_q[STOP_BIT];
  assign start_evt = we_rld && rld_q[STOP_BIT] && !wdata[STOP_BIT];
  assign stop_evt  = we_rld && !rld_q[STOP_BIT] && wdata[STOP_BIT];

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_evt),
    .en   (running),
    .tick (tick)
  );

  always_comb begin
    step   = count_step(cnt_q, rld_q[30:0]);
    expire = tick && step.expire && !stop_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q   <= 32'h8000_0000;
      vec_q   <= '0;
      dest_q  <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= expire;
      if (we_rld)  rld_q  <= wdata;
      if (we_vec)  vec_q  <= wdata;
      if (we_dest) dest_q <= wdata;
      if (start_evt)     cnt_q <= wdata[30:0];
      else if (stop_evt) cnt_q <= '0;
      else if (tick)     cnt_q <= step.cnt;
      if (expire) phase_q <= ~phase_q;
    end
  end

  assign cnt_word  = {phase_q, cnt_q};
  assign rld_word  = rld_q;
  assign vec_word  = vec_q;
  assign dest_word = dest_q;
  assign irq       = irq_q;
  assign tick_o    = tick;
  assign expire_o  = expire;
  assign run_o     = running;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int          N_TMR     = 4,
  parameter int          DIV_RATIO = 8,
  parameter logic [31:0] FREQ_RST  = 32'h0,
  localparam int         ADDR_W    = $clog2(GRP_BASE + N_TMR * GRP_STRIDE),
  localparam int         IDX_W     = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [N_TMR-1:0]  irq_pulse
);
  logic             hit_freq, hit_grp;
  logic [IDX_W-1:0] grp_idx;
  tmr_sel_e         sel;
  logic [WORD_W-1:0] freq_q;
  logic [WORD_W-1:0] cnt_w [N_TMR];
  logic [WORD_W-1:0] rld_w [N_TMR];
  logic [WORD_W-1:0] vec_w [N_TMR];
  logic [WORD_W-1:0] dst_w [N_TMR];
  logic [N_TMR-1:0]  ch_tick, ch_expire, ch_run;

  tmr_decode #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .hit_freq(hit_freq),
    .hit_grp (hit_grp),
    .grp_idx (grp_idx),
    .sel     (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 freq_q <= FREQ_RST;
    else if (wr_en && hit_freq) freq_q <= wdata;
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_ch
    logic grp_wr;
    assign grp_wr = wr_en && hit_grp && (grp_idx == IDX_W'(i));
    tmr_chan #(.DIV(DIV_RATIO)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_rld   (grp_wr && (sel == SEL_RLD)),
      .we_vec   (grp_wr && (sel == SEL_VEC)),
      .we_dest  (grp_wr && (sel == SEL_DEST)),
      .wdata    (wdata),
      .cnt_word (cnt_w[i]),
      .rld_word (rld_w[i]),
      .vec_word (vec_w[i]),
      .dest_word(dst_w[i]),
      .irq      (irq_pulse[i]),
      .tick_o   (ch_tick[i]),
      .expire_o (ch_expire[i]),
      .run_o    (ch_run[i])
    );
  end

  always_comb begin
    rdata = '1;
    if (hit_freq) begin
      rdata = freq_q;
    end else if (hit_grp) begin
      unique case (sel)
        SEL_CNT:  rdata = cnt_w[grp_idx];
        SEL_RLD:  rdata = rld_w[grp_idx];
        SEL_VEC:  rdata = vec_w[grp_idx];
        SEL_DEST: rdata = dst_w[grp_idx];
      endcase
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int N_TMR = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_TMR-1:0] irq,
  input logic [N_TMR-1:0] tick,
  input logic [N_TMR-1:0] expire,
  input logic [N_TMR-1:0] running
);
  for (genvar i = 0; i < N_TMR; i++) begin : g_a
    assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |=> !irq[i]);
    assert_pulse_from_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> $past(expire[i]));
    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] |=> !tick[i]);
    assert_prescale_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running[i]) |-> !tick[i]);
    assert_silent_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!running[i] && $past(!running[i])) |-> !irq[i]);
  end
endmodule

bind tmr_bank tmr_bank_chk #(.N_TMR(N_TMR)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq    (irq_pulse),
  .tick   (ch_tick),
  .expire (ch_expire),
  .running(ch_run)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  localparam logic [31:0] FREQ_INIT = 32'h017D_7840;
  localparam int NV = 21;
  // {write, addr[8:0], wdata, expected read}
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 9'h000, 32'h0, FREQ_INIT},              // R1 frequency reset
    {1'b0, 9'h020, 32'h0, 32'h8000_0000},          // R1 timer0 reload
    {1'b0, 9'h0A0, 32'h0, 32'h8000_0000},          // R1 timer2 reload
    {1'b0, 9'h010, 32'h0, 32'h0000_0000},          // R1 timer0 count
    {1'b1, 9'h030, 32'h1234_5678, 32'h0},          // R2 timer0 vector
    {1'b0, 9'h030, 32'h0, 32'h1234_5678},          // R2
    {1'b1, 9'h100, 32'hA5A5_0003, 32'h0},          // R2 timer3 destination
    {1'b0, 9'h100, 32'h0, 32'hA5A5_0003},          // R2
    {1'b1, 9'h070, 32'h0000_0001, 32'h0},          // R2 timer1 vector
    {1'b0, 9'h030, 32'h0, 32'h1234_5678},          // R2 no aliasing
    {1'b0, 9'h070, 32'h0, 32'h0000_0001},          // R2
    {1'b1, 9'h010, 32'h7FFF_FFFF, 32'h0},          // R4 count write
    {1'b0, 9'h010, 32'h0, 32'h0000_0000},          // R4 ignored
    {1'b1, 9'h034, 32'hFFFF_0000, 32'h0},          // R3 misaligned write
    {1'b0, 9'h030, 32'h0, 32'h1234_5678},          // R3 unchanged
    {1'b0, 9'h034, 32'h0, 32'hFFFF_FFFF},          // R3 misaligned read
    {1'b1, 9'h0E4, 32'h0000_0000, 32'h0},          // R3 misaligned reload write
    {1'b0, 9'h0E0, 32'h0, 32'h8000_0000},          // R3 timer3 still stopped
    {1'b1, 9'h000, 32'hCAFE_0001, 32'h0},          // R2 frequency write
    {1'b0, 9'h000, 32'h0, 32'hCAFE_0001},          // R2
    {1'b0, 9'h110, 32'h0, 32'hFFFF_FFFF}           // R3 outside map
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq_pulse;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tmr_bank #(.N_TMR(4), .DIV_RATIO(4), .FREQ_RST(FREQ_INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {28'd0, irq_pulse}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][73]) do_write(VEC[v][72:64], VEC[v][63:32]);
      else rd_chk($sformatf("R2/R3 table[%0d]", v), VEC[v][72:64], VEC[v][31:0]);
    end

    // Timer1 start with reload 3
    do_write(9'h060, 32'd3);
    rd_chk("R5 load on start", 9'h050, 32'd3);
    for (int k = 1; k <= 37; k++) begin
      @(negedge clk);
      chk("R10 other timers quiet", {28'd0, irq_pulse & 4'b1101}, 32'd0);
      if (k == 12 || k == 24 || k == 36) chk("R7 pulse on expiry", {31'd0, irq_pulse[1]}, 32'd1);
      else chk("R7 no pulse between expiries", {31'd0, irq_pulse[1]}, 32'd0);
      if (k == 4)  rd_chk("R6 first decrement", 9'h050, 32'd2);
      if (k == 8)  rd_chk("R6 second decrement", 9'h050, 32'd1);
      if (k == 12) rd_chk("R7 reload and phase flip", 9'h050, 32'h8000_0003);
      if (k == 16) rd_chk("R6 decrement after reload", 9'h050, 32'h8000_0002);
      if (k == 24) rd_chk("R7 phase flips back", 9'h050, 32'h0000_0003);
      if (k == 36) rd_chk("R7 third expiry", 9'h050, 32'h8000_0003);
    end

    // Stop: count cleared, phase kept
    do_write(9'h060, 32'h8000_0005);
    rd_chk("R8 stop keeps phase only", 9'h050, 32'h8000_0000);
    rd_chk("R8 reload word stored", 9'h060, 32'h8000_0005);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R8 no pulse when stopped", {28'd0, irq_pulse}, 32'd0);
    end
    rd_chk("R8 count stays cleared", 9'h050, 32'h8000_0000);

    // Restart with reload 2: prescaler restarts, phase kept
    do_write(9'h060, 32'd2);
    rd_chk("R5 restart load keeps phase", 9'h050, 32'h8000_0002);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (k == 8) begin
        chk("R5 exact first expiry after restart", {31'd0, irq_pulse[1]}, 32'd1);
        rd_chk("R7 reload after restart", 9'h050, 32'h0000_0002);
      end else begin
        chk("R5 no early pulse", {31'd0, irq_pulse[1]}, 32'd0);
      end
    end

    // Timer2 running with zero reload
    do_write(9'h0A0, 32'd0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R9 zero reload idle", {31'd0, irq_pulse[2]}, 32'd0);
    end
    rd_chk("R9 count stays zero", 9'h090, 32'd0);
    do_write(9'h0A0, 32'd2);
    rd_chk("R2 timer2 reload stored", 9'h0A0, 32'd2);
    pulses = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (irq_pulse[2]) pulses++;
    end
    chk("R9 resumes after non-zero reload", {31'd0, pulses != 0}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule